// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches eight already-synchronized GPIO input lines and raises interrupts from them under per-line control. Each line is set either to level sensing, where its status bit simply mirrors whether the pin sits at the chosen level, or to edge sensing, where a rising edge, a falling edge or either edge is captured into a sticky status bit that software must clear. A byte-wide register bus configures the lines, reads the raw and masked status, and clears captured edges. A single interrupt output is the OR of the masked status bits.

Each line's edge capture is a two-state machine. `LN_IDLE` means nothing is latched and `LN_PEND` means a captured edge is waiting. The transitions are:
- `T_CAPTURE` (`LN_IDLE` to `LN_PEND`): the selected edge is seen in edge mode.
- `T_CLEAR` (`LN_PEND` to `LN_IDLE`): a clear write hits the line and no new edge arrives in the same cycle.
- `T_FLUSH` (`LN_PEND` to `LN_IDLE`): the line is switched to level mode.
- `T_HOLD`: in every other case the line keeps its state.

Edges are found by comparing each pin with its value one clock earlier.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every configuration register, all raw and masked status bits and `irq_o` are 0, and every edge line is in `LN_IDLE`.
- R2: Register addresses are as follows:
  - 0 is the sense register. A bit of 1 gives level mode and 0 gives edge mode.
  - 1 is the dual-edge register.
  - 2 is the polarity register. A bit of 1 selects high level or rising edge, and 0 selects low level or falling edge.
  - 3 is the enable register.
  - 4 is the raw status and 5 is the masked status.
  - 6 is the clear register. It reads as 0.
  - 7 reads as 0.
  - Addresses 0 to 3 read back what was last written. `bus_rdata` always shows the register at `bus_addr`. A write needs `bus_sel` and `bus_wr` both high and takes effect at that clock edge.
- R3: For a line in level mode, the raw bit equals 1 exactly while the pin equals its polarity bit. It changes in the same cycle as the pin and needs no clear.
- R4: For a line in edge mode with its dual-edge bit 0, an edge of the chosen direction (a pin differing from its value one clock earlier) sets the raw bit at that clock edge. The bit stays set until cleared.
- R5: For a line in edge mode with its dual-edge bit 1, both rising and falling edges set the raw bit, and the polarity bit has no effect.
- R6: Writing a 1 to a bit of address 6 clears that line's latched edge. Writing a 0 bit leaves that line unchanged.
- R7: If an edge is detected in the same cycle as a clear of that line, the raw bit stays set.
- R8: Masked status equals raw status AND the enable register. `irq_o` is 1 exactly when any masked bit is 1.
- R9: Switching a line to level mode discards its latched edge, so it does not reappear when the line returns to edge mode.
- R10: Writes to addresses 4, 5 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronized GPIO line values |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Level-mode status, masked status, `irq_o` and read data are combinational. The bench checks them 1 ns after driving inputs on the falling edge, in the same cycle. Edge captures, clears and register writes take effect at the next rising edge. The bench's model applies them only after that edge, so their effect is checked in the following cycle's sample. Directed sequences cover the same-cycle edge/clear collision and the mode-switch flush. Seeded random traffic checks the result of every access against the model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE  = 3'd0,
        A_DUAL  = 3'd1,
        A_POL   = 3'd2,
        A_EN    = 3'd3,
        A_RAW   = 3'd4,
        A_MSK   = 3'd5,
        A_CLR   = 3'd6,
        A_SPARE = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      mode_o,
    output logic [N-1:0]      dual_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      clr_o
);
    logic [N-1:0] mode_q, dual_q, pol_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dual_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(addr))
                A_MODE:  mode_q <= wdata;
                A_DUAL:  dual_q <= wdata;
                A_POL:   pol_q  <= wdata;
                A_EN:    en_q   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_o = (wr_en && reg_addr_e'(addr) == A_CLR) ? wdata : '0;
    end

    assign mode_o = mode_q;
    assign dual_o = dual_q;
    assign pol_o  = pol_q;
    assign en_o   = en_q;

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= 3'd4) |=> ($stable(mode_q) && $stable(dual_q) && $stable(pol_q) && $stable(en_q)));
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic mode,
    input  logic dual,
    input  logic pol,
    input  logic clr,
    output logic raw
);
    line_state_e state_q, state_d;
    logic pin_d;
    logic rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin;
    end

    always_comb begin
        rise = pin & ~pin_d;
        fall = ~pin & pin_d;
        hit  = ~mode & (dual ? (rise | fall) : (pol ? rise : fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (hit) state_d = LN_PEND;                 // T_CAPTURE
            LN_PEND: begin
                if (mode)           state_d = LN_IDLE;            // T_FLUSH
                else if (clr && !hit) state_d = LN_IDLE;          // T_CLEAR
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        raw = mode ? (pin == pol) : (state_q == LN_PEND);
    end

    // R4
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> state_q == LN_PEND);
    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && clr && !hit) |=> state_q == LN_IDLE);
    // R9
    level_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> state_q == LN_IDLE);
    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PEND && !mode && !clr) |=> state_q == LN_PEND);
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pin_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq_o
);
    logic [N-1:0] mode, dual, pol, en, clr, raw, msk;

    gpio_irq_cfg #(.N(N)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_sel & bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .mode_o (mode),
        .dual_o (dual),
        .pol_o  (pol),
        .en_o   (en),
        .clr_o  (clr)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_irq_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_i[i]),
            .mode  (mode[i]),
            .dual  (dual[i]),
            .pol   (pol[i]),
            .clr   (clr[i]),
            .raw   (raw[i])
        );
    end

    assign msk   = raw & en;
    assign irq_o = |msk;

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_MODE:  bus_rdata = mode;
            A_DUAL:  bus_rdata = dual;
            A_POL:   bus_rdata = pol;
            A_EN:    bus_rdata = en;
            A_RAW:   bus_rdata = raw;
            A_MSK:   bus_rdata = msk;
            default: bus_rdata = '0;
        endcase
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en != '0));
    // R2
    clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CLR) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_irq_top.sv
module sim_gpio_irq_top;
    localparam int N = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic irq_o;
    int errors = 0, checks = 0;

    logic [N-1:0] m_mode, m_dual, m_pol, m_en, m_lat, m_pd;

    always #10 clk = ~clk;

    gpio_irq_top #(.N(N)) u0 (.*);

    function automatic logic [N-1:0] exp_raw(input logic [N-1:0] p);
        return (m_mode & ~(p ^ m_pol)) | (~m_mode & m_lat);
    endfunction

    function automatic logic [N-1:0] exp_read(input logic [2:0] a, input logic [N-1:0] p);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_dual;
            3'd2: return m_pol;
            3'd3: return m_en;
            3'd4: return exp_raw(p);
            3'd5: return exp_raw(p) & m_en;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] p, input logic s, input logic w,
                        input logic [2:0] a, input logic [N-1:0] d, input string tag);
        logic [N-1:0] rise, fall, hit, clr;
        @(negedge clk);
        pin_i = p; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        check(tag, bus_rdata, exp_read(a, p));
        check("R8 irq", {7'd0, irq_o}, {7'd0, |(exp_raw(p) & m_en)});
        rise = p & ~m_pd;
        fall = ~p & m_pd;
        hit  = ~m_mode & ((m_dual & (rise | fall)) | (~m_dual & ((m_pol & rise) | (~m_pol & fall))));
        clr  = (s && w && a == 3'd6) ? d : '0;
        @(posedge clk);
        m_lat = ~m_mode & (hit | (m_lat & ~clr));
        m_pd  = p;
        if (s && w) begin
            case (a)
                3'd0: m_mode = d;
                3'd1: m_dual = d;
                3'd2: m_pol  = d;
                3'd3: m_en   = d;
                default: ;
            endcase
        end
        // R9: a line just set to level has no latched edge
        m_lat = m_lat & ~m_mode;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] p, input string tag);
        step(p, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [N-1:0] p, input string tag);
        step(p, 1'b0, 1'b0, a, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_mode = '0; m_dual = '0; m_pol = '0; m_en = '0; m_lat = '0; m_pd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R2 map
        for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1");
        wr(3'd3, 8'hFF, '0, "R2"); rd(3'd3, '0, "R2");

        // R3 level mode
        wr(3'd0, 8'h0F, '0, "R3");
        wr(3'd2, 8'h05, '0, "R3");
        rd(3'd4, 8'h00, "R3"); rd(3'd4, 8'h0F, "R3"); rd(3'd5, 8'hF0, "R3"); rd(3'd4, 8'h00, "R3");

        // R4 single edge: upper rising, lower falling
        wr(3'd0, 8'h00, '0, "R4");
        wr(3'd2, 8'hF0, '0, "R4");
        wr(3'd6, 8'hFF, '0, "R4");
        rd(3'd4, 8'hFF, "R4"); rd(3'd4, 8'hFF, "R4");
        rd(3'd4, 8'h00, "R4"); rd(3'd4, 8'h00, "R4");

        // R6 clear only ones
        wr(3'd6, 8'h3C, 8'h00, "R6"); rd(3'd4, 8'h00, "R6");
        wr(3'd6, 8'h00, 8'h00, "R6"); rd(3'd4, 8'h00, "R6");

        // R5 dual edge, polarity ignored
        wr(3'd6, 8'hFF, 8'h00, "R5");
        wr(3'd1, 8'hFF, 8'h00, "R5");
        rd(3'd4, 8'h55, "R5"); rd(3'd4, 8'h55, "R5");
        wr(3'd6, 8'hFF, 8'h55, "R5"); rd(3'd4, 8'hAA, "R5"); rd(3'd4, 8'hAA, "R5");

        // R7 edge wins over same-cycle clear
        wr(3'd6, 8'hFF, 8'hAA, "R7");
        wr(3'd6, 8'hFF, 8'h00, "R7"); rd(3'd4, 8'h00, "R7");

        // R9 level switch discards latched edge
        rd(3'd4, 8'hFF, "R9"); rd(3'd4, 8'hFF, "R9");
        wr(3'd0, 8'hFF, 8'hFF, "R9"); rd(3'd4, 8'hFF, "R9");
        wr(3'd0, 8'h00, 8'hFF, "R9"); rd(3'd4, 8'hFF, "R9");

        // R10 read-only writes ignored
        wr(3'd4, 8'hFF, 8'hFF, "R10"); wr(3'd5, 8'hFF, 8'hFF, "R10"); wr(3'd7, 8'hFF, 8'hFF, "R10");
        for (int a = 0; a < 4; a++) rd(3'(a), 8'hFF, "R10");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] p, d;
            logic [2:0] a;
            logic s, w;
            p = ($urandom % 4 == 0) ? 8'($urandom) : pin_i ^ (8'(1) << ($urandom % 8));
            a = 3'($urandom);
            d = 8'($urandom);
            s = ($urandom % 3 == 0);
            w = ($urandom % 2 == 0);
            step(p, s, w, a, d, "R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule